// File: doc/BRIEF.md
# Double-Precision Issue Throttle

This block is the issue-control stage of a small in-order SIMD core. Instructions reach it one at a time over a valid/ready handshake. Each one carries a two-bit class and an opaque tag. The block decides, cycle by cycle, whether the head instruction may leave. The rules depend on the class of the head and on how recently a double-precision operation issued. The block also times the two arithmetic classes through to completion, and raises result pulses that carry the tag of the finishing instruction.

A mode input selects one of two policies. In the baseline policy, every double-precision issue freezes all issue for a fixed number of cycles. In the enhanced policy, only double-precision issues are spaced apart, and all other work keeps flowing. Three free-running counters make the resulting throughput visible: double-precision issues, single-precision issues and stalled cycles. Register files, forwarding, the arithmetic itself and fetch are outside this block.

Top module: `dp_issue_throttle`

## Requirements
- R1: An instruction issues on a rising edge where `inValid` and `inReady` are both high. A head that is not ready stays at the head and is never bypassed. The class codes on `inClass` are 2'b00 other, 2'b01 single precision, 2'b10 double precision, and 2'b11, which is handled as other.
- R2: With `enhMode` low, a double-precision issue blocks every class for the 6 edges that follow it. A head waiting behind it therefore issues on the 7th edge, which gives one double-precision issue per 7 cycles at most.
- R3: With `enhMode` high, two double-precision issues are always at least 2 edges apart. A double-precision head that arrives right after one waits exactly one cycle, and anything queued behind it waits as well.
- R4: With `enhMode` high, a head of class other or single precision is always ready, whatever the double-precision history.
- R5: A single-precision instruction that issues on edge E gives one `spDoneValid` pulse, sampled on edge E+6, with `spDoneTag` equal to its tag.
- R6: A double-precision instruction that issues on edge E gives two `dpLaneValid` pulses carrying its tag. The first is sampled on edge E+12 with `dpLaneLast` low. The second is sampled on edge E+13 with `dpLaneLast` high, and it marks the valid result.
- R7: A single-precision completion and a double-precision lane pulse may occur in the same cycle, each on its own outputs.
- R8: `dpIssueCount` and `spIssueCount` each add one per issue of their class. `stallCount` adds one per edge on which `inValid` is high and `inReady` is low. All three wrap.
- R9: While `rstN` is low, the block holds `inReady` high, clears all counters and drops every completion that is in flight, so no pulse from before the reset appears afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enhMode | input | 1 | 0 selects the baseline policy, 1 the enhanced policy; change it only while the block is empty |
| inValid | input | 1 | Head instruction present |
| inClass | input | 2 | Class of the head instruction |
| inTag | input | TAG_W | Opaque tag of the head instruction |
| inReady | output | 1 | Head may issue on this edge |
| spDoneValid | output | 1 | Single-precision completion |
| spDoneTag | output | TAG_W | Tag of the single-precision completion |
| dpLaneValid | output | 1 | Double-precision lane completion |
| dpLaneLast | output | 1 | Marks the second lane, which is the result-valid pulse |
| dpLaneTag | output | TAG_W | Tag of the double-precision lane |
| dpIssueCount | output | CNT_W | Double-precision issues so far |
| spIssueCount | output | CNT_W | Single-precision issues so far |
| stallCount | output | CNT_W | Stalled cycles so far |

## Verification
Wrong stall or gap state shows at `inReady` within one cycle. In the baseline policy it shows as a wait other than 6 cycles behind a double-precision issue. In the enhanced policy it shows as a single-precision or other head being held, or as two double-precision issues one cycle apart. The bench measures each wait in edges and compares it with the value the policy dictates. A fault in the latency lines shows at the completion outputs 6, 12 or 13 edges after the issue, as a missing pulse, an early or late pulse, or a wrong tag. The bench matches every pulse against the issue edge it recorded for that tag. Counter faults show at the end of the run, when the totals are compared.

// File: rtl/dpthr_pkg.sv
package dpthr_pkg;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'b00,
    CLS_SP    = 2'b01,
    CLS_DP    = 2'b10,
    CLS_SPARE = 2'b11
  } instClass_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic issueSp;
    logic issueDp;
    logic stall;
  } issueStrobe_t;

endpackage

// File: rtl/dpthr_delay_line.sv
module dpthr_delay_line #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [W-1:0] inData,
  output logic         outValid,
  output logic [W-1:0] outData
);

  logic [W:0] stage [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else begin
      for (int i = DEPTH - 1; i > 0; i--) stage[i] <= stage[i-1];
      stage[0] <= {inValid, inData};
    end
  end

  assign outValid = stage[DEPTH-1][W];
  assign outData  = stage[DEPTH-1][W-1:0];

endmodule

// File: rtl/dpthr_ctrl.sv
module dpthr_ctrl
  import dpthr_pkg::*;
#(
  parameter int BASE_STALL = 6,
  parameter int ENH_GAP    = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enhMode,
  input  logic         inValid,
  input  logic [1:0]   inClass,
  output logic         inReady,
  output issueStrobe_t strobe
);

  localparam int STALL_W = $clog2(BASE_STALL + 1);
  localparam int GAP_W   = $clog2(ENH_GAP + 1);

  logic [STALL_W-1:0] stallCnt;
  logic [GAP_W-1:0]   gapCnt;
  instClass_e         headCls;
  logic               headIsDp;
  logic               headIsSp;
  logic               baseBlocked;
  logic               gapBlocked;
  logic               fire;

  assign headCls     = instClass_e'(inClass);
  assign headIsDp    = (headCls == CLS_DP);
  assign headIsSp    = (headCls == CLS_SP);
  assign baseBlocked = (stallCnt != '0);
  assign gapBlocked  = headIsDp && (gapCnt != '0);

  assign inReady = enhMode ? !gapBlocked : !baseBlocked;
  assign fire    = inValid && inReady;

  assign strobe.issueSp = fire && headIsSp;
  assign strobe.issueDp = fire && headIsDp;
  assign strobe.stall   = inValid && !inReady;

  // baseline: whole-pipe freeze after a double-precision issue
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stallCnt <= '0;
    end else if (strobe.issueDp && !enhMode) begin
      stallCnt <= STALL_W'(BASE_STALL);
    end else if (baseBlocked) begin
      stallCnt <= stallCnt - STALL_W'(1);
    end
  end

  // enhanced: spacing between double-precision issues only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (strobe.issueDp && enhMode) begin
      gapCnt <= GAP_W'(ENH_GAP - 1);
    end else if (gapCnt != '0) begin
      gapCnt <= gapCnt - GAP_W'(1);
    end
  end

endmodule

// File: rtl/dpthr_datapath.sv
module dpthr_datapath
  import dpthr_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int SP_LAT = 6,
  parameter int DP_LAT = 13,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  issueStrobe_t     strobe,
  input  logic [TAG_W-1:0] inTag,
  output logic             spDoneValid,
  output logic [TAG_W-1:0] spDoneTag,
  output logic             dpLaneValid,
  output logic             dpLaneLast,
  output logic [TAG_W-1:0] dpLaneTag,
  output logic [CNT_W-1:0] dpIssueCount,
  output logic [CNT_W-1:0] spIssueCount,
  output logic [CNT_W-1:0] stallCount
);

  localparam int LANE0_DEPTH = DP_LAT - 1;

  logic             lane0Valid;
  logic [TAG_W-1:0] lane0Tag;
  logic             lane1Valid;
  logic [TAG_W-1:0] lane1Tag;

  dpthr_delay_line #(.DEPTH(SP_LAT), .W(TAG_W)) u_spLine (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (strobe.issueSp),
    .inData   (inTag),
    .outValid (spDoneValid),
    .outData  (spDoneTag)
  );

  dpthr_delay_line #(.DEPTH(LANE0_DEPTH), .W(TAG_W)) u_dpLane0 (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (strobe.issueDp),
    .inData   (inTag),
    .outValid (lane0Valid),
    .outData  (lane0Tag)
  );

  // second lane follows the first through the one shared datapath
  dpthr_delay_line #(.DEPTH(1), .W(TAG_W)) u_dpLane1 (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (lane0Valid),
    .inData   (lane0Tag),
    .outValid (lane1Valid),
    .outData  (lane1Tag)
  );

  assign dpLaneValid = lane0Valid || lane1Valid;
  assign dpLaneLast  = lane1Valid;
  assign dpLaneTag   = lane1Valid ? lane1Tag : lane0Tag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpIssueCount <= '0;
      spIssueCount <= '0;
      stallCount   <= '0;
    end else begin
      if (strobe.issueDp) dpIssueCount <= dpIssueCount + CNT_W'(1);
      if (strobe.issueSp) spIssueCount <= spIssueCount + CNT_W'(1);
      if (strobe.stall)   stallCount   <= stallCount + CNT_W'(1);
    end
  end

endmodule

// File: rtl/dp_issue_throttle.sv
module dp_issue_throttle
  import dpthr_pkg::*;
#(
  parameter int TAG_W        = 8,
  parameter int SP_LAT       = 6,
  parameter int DP_ARITH_LAT = 9,
  parameter int DP_MOVE_LAT  = 4,
  parameter int BASE_STALL   = 6,
  parameter int ENH_GAP      = 2,
  parameter int CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enhMode,
  input  logic             inValid,
  input  logic [1:0]       inClass,
  input  logic [TAG_W-1:0] inTag,
  output logic             inReady,
  output logic             spDoneValid,
  output logic [TAG_W-1:0] spDoneTag,
  output logic             dpLaneValid,
  output logic             dpLaneLast,
  output logic [TAG_W-1:0] dpLaneTag,
  output logic [CNT_W-1:0] dpIssueCount,
  output logic [CNT_W-1:0] spIssueCount,
  output logic [CNT_W-1:0] stallCount
);

  localparam int DP_LAT = DP_ARITH_LAT + DP_MOVE_LAT;

  issueStrobe_t strobe;

  dpthr_ctrl #(.BASE_STALL(BASE_STALL), .ENH_GAP(ENH_GAP)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enhMode (enhMode),
    .inValid (inValid),
    .inClass (inClass),
    .inReady (inReady),
    .strobe  (strobe)
  );

  dpthr_datapath #(
    .TAG_W(TAG_W), .SP_LAT(SP_LAT), .DP_LAT(DP_LAT), .CNT_W(CNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .inTag        (inTag),
    .spDoneValid  (spDoneValid),
    .spDoneTag    (spDoneTag),
    .dpLaneValid  (dpLaneValid),
    .dpLaneLast   (dpLaneLast),
    .dpLaneTag    (dpLaneTag),
    .dpIssueCount (dpIssueCount),
    .spIssueCount (spIssueCount),
    .stallCount   (stallCount)
  );

endmodule

// File: rtl/dpthr_checker.sv
module dpthr_checker
  import dpthr_pkg::*;
#(
  parameter int BASE_STALL = 6,
  parameter int ENH_GAP    = 2,
  parameter int TAG_W      = 8,
  parameter int CNT_W      = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enhMode,
  input logic             inValid,
  input logic [1:0]       inClass,
  input logic             inReady,
  input logic             dpLaneValid,
  input logic             dpLaneLast,
  input logic [TAG_W-1:0] dpLaneTag,
  input logic [CNT_W-1:0] stallCount
);

  localparam int SINCE_W = $clog2(BASE_STALL + ENH_GAP + 2) + 1;

  logic [SINCE_W-1:0] sinceDp;
  logic               fireDp;

  assign fireDp = inValid && inReady && (inClass == CLS_DP);

  // edges elapsed since the last double-precision issue, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceDp <= '1;
    else if (fireDp) sinceDp <= '0;
    else if (sinceDp != '1) sinceDp <= sinceDp + SINCE_W'(1);
  end

  assert_base_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!enhMode && inValid && inReady) |-> (int'(sinceDp) >= BASE_STALL));

  assert_dp_spacing_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enhMode && fireDp) |-> (int'(sinceDp) >= ENH_GAP - 1));

  assert_nondp_free_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enhMode && inValid && (inClass != CLS_DP)) |-> inReady);

  assert_lane_pair_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dpLaneValid && !dpLaneLast) |=> (dpLaneValid && dpLaneLast && dpLaneTag == $past(dpLaneTag)));

  assert_stall_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inReady) |=> (stallCount == $past(stallCount) + CNT_W'(1)));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && !inReady) |=> $stable(stallCount));

endmodule

bind dp_issue_throttle dpthr_checker #(
  .BASE_STALL(BASE_STALL), .ENH_GAP(ENH_GAP), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enhMode     (enhMode),
  .inValid     (inValid),
  .inClass     (inClass),
  .inReady     (inReady),
  .dpLaneValid (dpLaneValid),
  .dpLaneLast  (dpLaneLast),
  .dpLaneTag   (dpLaneTag),
  .stallCount  (stallCount)
);

// File: tb/dp_issue_throttle_tb.sv
module dp_issue_throttle_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TAG_W      = 8;
  localparam int CNT_W      = 16;
  localparam int SP_LAT     = 6;
  localparam int DP_LAT     = 13;

  typedef struct packed {
    logic       mode;
    logic [1:0] cls;
    logic [3:0] expWait;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd2, 4'd0}, '{1'b0, 2'd1, 4'd6}, '{1'b0, 2'd0, 4'd0}, '{1'b0, 2'd2, 4'd0},
    '{1'b0, 2'd2, 4'd6}, '{1'b0, 2'd1, 4'd6}, '{1'b0, 2'd1, 4'd0},
    '{1'b1, 2'd2, 4'd0}, '{1'b1, 2'd2, 4'd1}, '{1'b1, 2'd1, 4'd0}, '{1'b1, 2'd2, 4'd0},
    '{1'b1, 2'd0, 4'd0}, '{1'b1, 2'd1, 4'd0}, '{1'b1, 2'd2, 4'd0}, '{1'b1, 2'd2, 4'd1},
    '{1'b1, 2'd3, 4'd0},
    '{1'b0, 2'd1, 4'd0}, '{1'b0, 2'd2, 4'd0}, '{1'b0, 2'd2, 4'd6}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enhMode = 1'b0;
  logic             inValid = 1'b0;
  logic [1:0]       inClass = 2'd0;
  logic [TAG_W-1:0] inTag = '0;
  logic             inReady;
  logic             spDoneValid;
  logic [TAG_W-1:0] spDoneTag;
  logic             dpLaneValid;
  logic             dpLaneLast;
  logic [TAG_W-1:0] dpLaneTag;
  logic [CNT_W-1:0] dpIssueCount;
  logic [CNT_W-1:0] spIssueCount;
  logic [CNT_W-1:0] stallCount;

  dp_issue_throttle u_dut (
    .clk(clk), .rstN(rstN), .enhMode(enhMode), .inValid(inValid), .inClass(inClass),
    .inTag(inTag), .inReady(inReady), .spDoneValid(spDoneValid), .spDoneTag(spDoneTag),
    .dpLaneValid(dpLaneValid), .dpLaneLast(dpLaneLast), .dpLaneTag(dpLaneTag),
    .dpIssueCount(dpIssueCount), .spIssueCount(spIssueCount), .stallCount(stallCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int edgeCnt = 0;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  int         total = 0;
  int         bad = 0;
  bit         finished = 0;
  int         issueEdge [256];
  logic [1:0] issueCls [256];
  logic [7:0] nextTag = 8'd0;
  int         expDp = 0, expSp = 0, expStall = 0;
  int         spDoneN = 0, lane0N = 0, lane1N = 0;
  bit         bothSeen = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // present one instruction at a falling edge, return cycles spent waiting
  task automatic issueOne(input logic [1:0] cls, output int waits);
    inValid = 1'b1;
    inClass = cls;
    inTag   = nextTag;
    issueCls[nextTag] = cls;
    waits = 0;
    forever begin
      #1;
      if (inReady) begin
        issueEdge[nextTag] = edgeCnt + 1;
        @(negedge clk);
        break;
      end
      waits++;
      @(negedge clk);
    end
    if (cls == 2'd2) expDp++;
    if (cls == 2'd1) expSp++;
    expStall += waits;
    nextTag++;
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // completion monitor: latency and tag of every pulse
  always @(negedge clk) begin
    if (rstN) begin
      if (spDoneValid) begin
        spDoneN++;
        check(issueCls[spDoneTag] == 2'd1 && edgeCnt + 1 - issueEdge[spDoneTag] == SP_LAT,
              "R5", "sp completion latency", edgeCnt + 1 - issueEdge[spDoneTag], SP_LAT);
      end
      if (dpLaneValid) begin
        if (!dpLaneLast) begin
          lane0N++;
          check(edgeCnt + 1 - issueEdge[dpLaneTag] == DP_LAT - 1, "R6", "dp lane0 latency",
                edgeCnt + 1 - issueEdge[dpLaneTag], DP_LAT - 1);
        end else begin
          lane1N++;
          check(edgeCnt + 1 - issueEdge[dpLaneTag] == DP_LAT, "R6", "dp lane1 latency",
                edgeCnt + 1 - issueEdge[dpLaneTag], DP_LAT);
        end
      end
      if (spDoneValid && dpLaneValid) bothSeen = 1;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", edgeCnt, 0);
    finishRun();
  end

  initial begin
    int w;
    int firstTag;
    int lastTag;
    string r;
    bit sawOut;

    repeat (3) @(negedge clk);
    // R9: reset state
    check(inReady == 1'b1, "R9", "ready in reset", inReady, 1);
    check(!spDoneValid && !dpLaneValid, "R9", "no completion in reset", spDoneValid, 0);
    check(dpIssueCount == 0 && spIssueCount == 0, "R9", "issue counters in reset",
          int'(dpIssueCount) + int'(spIssueCount), 0);
    check(stallCount == 0, "R9", "stall counter in reset", int'(stallCount), 0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: waits under both policies (R1 R2 R3 R4)
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].mode != enhMode) begin
        idle(20);
        enhMode = VECS[i].mode;
        @(negedge clk);
      end
      issueOne(VECS[i].cls, w);
      if (VECS[i].cls == 2'd3) r = "R1";
      else if (!VECS[i].mode) r = "R2";
      else if (VECS[i].cls == 2'd2) r = "R3";
      else r = "R4";
      check(w == int'(VECS[i].expWait), r, $sformatf("wait of vector %0d", i), w,
            int'(VECS[i].expWait));
    end
    idle(20);

    // R2: back-to-back double precision, baseline, one per 7 cycles
    enhMode = 1'b0;
    @(negedge clk);
    firstTag = int'(nextTag);
    for (int i = 0; i < 14; i++) issueOne(2'd2, w);
    lastTag = int'(nextTag) - 1;
    check(issueEdge[lastTag] - issueEdge[firstTag] == 13 * 7, "R2", "baseline dp span",
          issueEdge[lastTag] - issueEdge[firstTag], 13 * 7);
    idle(20);

    // R3: back-to-back double precision, enhanced, one per 2 cycles
    enhMode = 1'b1;
    @(negedge clk);
    firstTag = int'(nextTag);
    for (int i = 0; i < 10; i++) issueOne(2'd2, w);
    lastTag = int'(nextTag) - 1;
    check(issueEdge[lastTag] - issueEdge[firstTag] == 9 * 2, "R3", "enhanced dp span",
          issueEdge[lastTag] - issueEdge[firstTag], 9 * 2);
    idle(20);

    // R7: sp completion in the same cycle as the dp result lane
    bothSeen = 0;
    issueOne(2'd2, w);
    for (int i = 0; i < 6; i++) issueOne(2'd0, w);
    issueOne(2'd1, w);
    idle(20);
    check(bothSeen, "R7", "simultaneous sp and dp completion", int'(bothSeen), 1);

    // R8 and completion totals
    check(int'(dpIssueCount) == expDp, "R8", "dp issue count", int'(dpIssueCount), expDp);
    check(int'(spIssueCount) == expSp, "R8", "sp issue count", int'(spIssueCount), expSp);
    check(int'(stallCount) == expStall, "R8", "stall count", int'(stallCount), expStall);
    check(spDoneN == expSp, "R5", "sp completion count", spDoneN, expSp);
    check(lane0N == expDp && lane1N == expDp, "R6", "dp lane counts", lane0N + lane1N, 2 * expDp);

    // R9: reset while stalled flushes everything
    enhMode = 1'b0;
    inValid = 1'b1;
    inClass = 2'd2;
    inTag   = nextTag;
    nextTag++;
    @(negedge clk);
    inClass = 2'd1;
    @(negedge clk);
    #1;
    check(inReady == 1'b0, "R2", "sp held behind dp", inReady, 0);
    rstN = 1'b0;
    #1;
    check(inReady == 1'b1, "R9", "ready after mid-stall reset", inReady, 1);
    check(dpIssueCount == 0 && stallCount == 0, "R9", "counters after mid-stall reset",
          int'(dpIssueCount) + int'(stallCount), 0);
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    sawOut = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (dpLaneValid || spDoneValid) sawOut = 1;
    end
    check(!sawOut, "R9", "no completion after reset flush", int'(sawOut), 0);

    finishRun();
  end

endmodule